// File: doc/BRIEF.md
# Conversion Result Register with Ready Flag

This block keeps the most recent converter sample and tells a host, through an active-low ready output, when that sample is new and safe to fetch. A host talks to it over a simple synchronous serial link: it lowers the frame select, shifts in an 8-bit command, and then shifts a data phase in or out, most significant bit first. Bits are taken on rising edges of the bit clock. Read data is valid on `sdo` before each rising edge. The link and the sample strobe are synchronous to `clk`.

A new sample normally lands in the register at once and pulls ready low. If the previous sample has not been fetched when the next one arrives, the block raises ready for a fixed guard interval and only then loads the waiting sample. A host that sees ready high therefore knows not to begin a fetch. A read of the result copies the register into a shadow shifter when the command completes, so an update can never tear a word that is being shifted out. The fetched word length is 24 or 16 bits, chosen by one bit in a small configuration word.

Top module: `result_reg_ready`

## Requirements
- R1: After reset the result is zero, `ready_n` is 1 and the word length is 24 bits.
- R2: When `smp_stb` is sampled high while `ready_n` is 1 and no guard interval is running, the sample is loaded at that edge and `ready_n` is 0 from that edge on.
- R3: A result read in 24-bit mode shifts out all 24 bits MSB first, and `ready_n` becomes 1 at the edge that takes the last bit.
- R4: In 16-bit mode a result read shifts out the upper 16 bits of the sample, and `ready_n` becomes 1 at the edge that takes the 16th bit.
- R5: When `smp_stb` is sampled high while `ready_n` is 0, `ready_n` is 1 for exactly GUARD cycles. The new sample is then loaded and `ready_n` falls at that edge. The result does not change during the interval, and further strobes inside it only replace the waiting sample.
- R6: A result read whose command ends during a guard interval returns the older value. If that read ends after the new value is loaded, `ready_n` stays 0.
- R7: A write command to the result is followed by a data phase of the current word length. The data is thrown away, and the next 8 bits in the same frame are decoded as a command.
- R8: A status read returns 8 bits: bit 7 is the current `ready_n` and bit 0 is the word-length bit (1 means 24 bits). All other bits are 0.
- R9: The configuration word is 16 bits. A 16-bit write sets the word length from bit 8, and a read returns that bit at position 8 with all other bits 0. The word length resets to 1.
- R10: While `cs_n` is high the interface returns to waiting for a command, and `sdo` is 0 from the next cycle. A frame cut short is forgotten.
- R11: Command byte: bit 6 = 1 for read, 0 for write. Bits 2..0 select the target: 0 status, 1 result, 2 configuration. A write to the status or any other address has no data phase, and the next byte is taken as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the guard interval counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe: a new sample is on `smp_data` |
| smp_data | input | 24 | New converter sample |
| cs_n | input | 1 | Frame select, low during a transaction |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| ready_n | output | 1 | Low while an unread sample is held |

## Verification
On every cycle the assertions check these properties: ready is held high while a guard interval runs, and the result never changes while the interval still has more than one cycle to go. Whenever the result does change, ready is low. The word length changes only from a write phase, and `sdo` is quiet after a deselect. The bench scenarios cover the rest, because each needs a full host transaction to show it. These are the MSB-first data values in both word lengths, the exact guard length, the old value returned by a read started in the guard, the ready flag staying low after a read that spans a load, and a dummy write consuming exactly its data phase.

// File: rtl/result_reg_ready.sv
module result_reg_ready #(
  parameter int DW     = 24,
  parameter int SHORT  = 16,
  parameter int GUARD  = 100,
  parameter int CMDW   = 8,
  parameter int WL_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [DW-1:0] smp_data,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          ready_n
);
  localparam int GW  = $clog2(GUARD + 1);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_RES  = 3'd1;
  localparam logic [2:0] A_CFG  = 3'd2;

  typedef enum logic [1:0] {S_CMD = 2'd0, S_RD = 2'd1, S_WR = 2'd2} st_t;

  st_t            st;
  logic           sclk_q;
  logic [BCW-1:0] bcnt, blen;
  logic [CMDW-2:0] cmd_sr;
  logic [2:0]     sel;
  logic [DW-1:0]  sh, res_q, pend;
  logic [SHORT-2:0] wr_sr;
  logic           wl, fresh;
  logic [GW-1:0]  gcnt;

  wire            rise     = sclk & ~sclk_q;
  wire [CMDW-1:0] cmd_byte = {cmd_sr, sdi};
  wire            is_rd    = cmd_byte[6];
  wire [2:0]      cmd_addr = cmd_byte[2:0];
  wire            cmd_done = rise && st == S_CMD && bcnt == BCW'(CMDW - 1);
  wire            last     = rise && st != S_CMD && bcnt == blen - 1'b1;
  wire            rd_done  = last && st == S_RD && sel == A_RES;
  wire            res_go   = cmd_done && is_rd && cmd_addr == A_RES;
  wire            load_g   = gcnt == GW'(1);
  wire [SHORT-1:0] wr_word = {wr_sr, sdi};
  wire [7:0]      stat     = {ready_n, 6'b0, wl};
  wire [SHORT-1:0] cfg_w   = SHORT'(wl) << WL_BIT;
  wire [BCW-1:0]  n_len    = wl ? BCW'(DW) : BCW'(SHORT);

  assign sdo = (st == S_RD) & sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      st     <= S_CMD;
      bcnt   <= '0;
      blen   <= '0;
      cmd_sr <= '0;
      sel    <= A_STAT;
      sh     <= '0;
      wr_sr  <= '0;
      wl     <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        st   <= S_CMD;
        bcnt <= '0;
      end else if (rise) begin
        case (st)
          S_CMD: begin
            cmd_sr <= cmd_byte[CMDW-2:0];
            if (bcnt == BCW'(CMDW - 1)) begin
              bcnt <= '0;
              sel  <= cmd_addr;
              case (cmd_addr)
                A_STAT: if (is_rd) begin
                  sh   <= {stat, {(DW-8){1'b0}}};
                  blen <= BCW'(8);
                  st   <= S_RD;
                end
                A_RES: begin
                  sh   <= wl ? res_q : {res_q[DW-1 -: SHORT], {(DW-SHORT){1'b0}}};
                  blen <= n_len;
                  st   <= is_rd ? S_RD : S_WR;
                end
                A_CFG: begin
                  sh   <= {cfg_w, {(DW-SHORT){1'b0}}};
                  blen <= BCW'(SHORT);
                  st   <= is_rd ? S_RD : S_WR;
                end
                default: st <= S_CMD;
              endcase
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          S_RD, S_WR: begin
            sh    <= sh << 1;
            wr_sr <= wr_word[SHORT-2:0];
            if (last) begin
              st   <= S_CMD;
              bcnt <= '0;
              if (st == S_WR && sel == A_CFG) wl <= wr_word[WL_BIT];
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          default: st <= S_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      pend    <= '0;
      ready_n <= 1'b1;
      gcnt    <= '0;
      fresh   <= 1'b0;
    end else if (load_g) begin
      res_q   <= pend;
      ready_n <= 1'b0;
      gcnt    <= '0;
      fresh   <= 1'b0;
    end else begin
      if (gcnt > GW'(1)) gcnt <= gcnt - 1'b1;
      if (res_go) fresh <= 1'b1;
      if (rd_done && fresh) ready_n <= 1'b1;
      if (smp_stb) begin
        if (gcnt != '0) begin
          pend <= smp_data;
        end else if (ready_n) begin
          res_q   <= smp_data;
          ready_n <= 1'b0;
          fresh   <= 1'b0;
        end else begin
          pend    <= smp_data;
          gcnt    <= GW'(GUARD);
          ready_n <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/result_reg_ready_chk.sv
module result_reg_ready_chk #(
  parameter int DW    = 24,
  parameter int GUARD = 100,
  parameter int GW    = $clog2(GUARD + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdo,
  input logic          ready_n,
  input logic          wl,
  input logic [1:0]    st,
  input logic [GW-1:0] gcnt,
  input logic [DW-1:0] res
);
  p_guard_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gcnt != '0) |-> ready_n);
  p_guard_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt <= GW'(GUARD));
  p_res_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gcnt > GW'(1)) |=> $stable(res));
  p_load_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res) |-> !ready_n);
  p_idle_sdo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo);
  p_wl_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wl) |-> $past(st) == 2'd2);
endmodule

bind result_reg_ready result_reg_ready_chk #(.DW(DW), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .ready_n(ready_n),
  .wl(wl), .st(st), .gcnt(gcnt), .res(res_q)
);

// File: tb/sim_result_reg_ready.sv
module sim_result_reg_ready;
  localparam int GUARD = 100;

  logic clk = 0, rst_n = 0, smp_stb = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [23:0] smp_data = '0;
  wire sdo, ready_n;

  result_reg_ready #(.GUARD(GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .ready_n(ready_n));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0;
  int start_req = 0, done_req = 0;

  // reference model of the ready flag
  int m_g, ss, ds;
  bit m_rdy, m_fresh;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdy = 1; m_g = 0; m_fresh = 0; ss = start_req; ds = done_req;
    end else begin
      bit st_ev, dn_ev, old_r;
      int old_g;
      st_ev = start_req != ss; dn_ev = done_req != ds;
      ss = start_req; ds = done_req;
      old_r = m_rdy; old_g = m_g;
      if (old_g == 1) begin
        m_rdy = 0; m_g = 0; m_fresh = 0;
      end else begin
        if (m_g > 1) m_g--;
        if (st_ev) m_fresh = 1;
        if (dn_ev && m_fresh) m_rdy = 1;
        if (smp_stb && old_g == 0) begin
          if (old_r) begin m_rdy = 0; m_fresh = 0; end
          else begin m_g = GUARD; m_rdy = 1; end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    c_chk++;
    if (ready_n !== m_rdy) begin
      c_fail++;
      $display("FAIL R2/R3/R5/R6 ready_n per-cycle: got %0b exp %0b at %0t", ready_n, m_rdy, $time);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic shift(input int n, input logic [31:0] dout, input bit ev_s,
                       input bit ev_d, output logic [31:0] din);
    din = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 0; sdi = dout[i];
      @(negedge clk); din = {din[30:0], sdo}; sclk = 1;
      if (i == 0 && ev_s) start_req++;
      if (i == 0 && ev_d) done_req++;
    end
    @(negedge clk); sclk = 0;
  endtask

  task automatic frame_on;  @(negedge clk); cs_n = 0; endtask
  task automatic frame_off; @(negedge clk); cs_n = 1; @(negedge clk); endtask

  task automatic strobe(input logic [23:0] d);
    @(negedge clk); smp_stb = 1; smp_data = d;
    @(negedge clk); smp_stb = 0;
  endtask

  task automatic read_res(input int n, output logic [31:0] d);
    logic [31:0] x;
    frame_on();
    shift(8, 32'h41, 1, 0, x);
    shift(n, 0, 0, 1, d);
    frame_off();
  endtask

  task automatic read_reg(input logic [2:0] a, input int n, output logic [31:0] d);
    logic [31:0] x;
    frame_on();
    shift(8, {25'b0, 1'b1, 3'b0, a}, 0, 0, x);
    shift(n, 0, 0, 0, d);
    frame_off();
  endtask

  task automatic write_cfg(input logic [15:0] v);
    logic [31:0] x;
    frame_on();
    shift(8, 32'h02, 0, 0, x);
    shift(16, {16'b0, v}, 0, 0, x);
    frame_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", (n_chk + c_chk) - (n_fail + c_fail), n_chk + c_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d, x;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R8 status layout
    check("R1 ready_n after reset", 32'(ready_n), 1);
    read_reg(3'd0, 8, d);  check("R1/R8 status after reset", d, 32'h81);
    read_res(24, d);       check("R1 result after reset", d, 0);

    // R2 immediate load, R3 24-bit read
    strobe(24'hA5C3E1);
    check("R2 ready_n low after load", 32'(ready_n), 0);
    read_reg(3'd0, 8, d);  check("R8 status with unread sample", d, 32'h01);
    read_res(24, d);       check("R3 24-bit read value", d, 32'hA5C3E1);
    check("R3 ready_n high after read", 32'(ready_n), 1);

    // R5 guard interval length
    strobe(24'h123456);
    repeat (3) @(negedge clk);
    @(negedge clk); smp_stb = 1; smp_data = 24'h0F1E2D;
    @(negedge clk); smp_stb = 0;
    cnt = 0;
    while (ready_n && cnt < 1000) begin cnt++; @(negedge clk); end
    check("R5 guard cycles with ready high", cnt, GUARD);
    read_res(24, d);       check("R5 value after guard", d, 32'h0F1E2D);

    // R6 read inside guard sees old value
    strobe(24'h334455);
    strobe(24'h667788);
    repeat (3) @(negedge clk);
    read_res(24, d);       check("R6 read in guard returns old", d, 32'h334455);
    cnt = 0;
    while (ready_n && cnt < 1000) begin cnt++; @(negedge clk); end
    read_res(24, d);       check("R6 value after guard", d, 32'h667788);

    // R6 read spanning the load keeps ready low
    strobe(24'h99AABB);
    strobe(24'hCCDDEE);
    repeat (70) @(negedge clk);
    read_res(24, d);       check("R6 spanning read returns old", d, 32'h99AABB);
    check("R6 ready stays low after spanning read", 32'(ready_n), 0);
    read_res(24, d);       check("R6 new value after spanning read", d, 32'hCCDDEE);

    // R7 dummy write consumes full data phase
    strobe(24'h5A5A5A);
    frame_on();
    shift(8, 32'h01, 0, 0, x);
    shift(24, 32'hFFFFFF, 0, 0, x);
    shift(8, 32'h40, 0, 0, x);
    shift(8, 0, 0, 0, d);
    frame_off();
    check("R7 status after dummy write", d, 32'h01);
    read_res(24, d);       check("R7 write data discarded", d, 32'h5A5A5A);

    // R9 / R4 word length
    write_cfg(16'h0000);
    read_reg(3'd0, 8, d);  check("R9 status wl cleared", d, 32'h80);
    read_reg(3'd2, 16, d); check("R9 config readback 16-bit mode", d, 32'h0000);
    strobe(24'hBEEF42);
    read_res(16, d);       check("R4 16-bit read upper bits", d, 32'hBEEF);
    check("R4 ready high after 16 bits", 32'(ready_n), 1);
    write_cfg(16'h0100);
    read_reg(3'd2, 16, d); check("R9 config readback 24-bit mode", d, 32'h0100);

    // R10 aborted frame
    frame_on();
    shift(4, 32'hF, 0, 0, x);
    frame_off();
    check("R10 sdo idle while deselected", 32'(sdo), 0);
    read_reg(3'd0, 8, d);  check("R10 status after abort", d, 32'h81);

    // R11 unknown address and status write have no data phase
    frame_on();
    shift(8, 32'h45, 0, 0, x);
    shift(8, 32'h00, 0, 0, x);
    shift(8, 32'h40, 0, 0, x);
    shift(8, 0, 0, 0, d);
    frame_off();
    check("R11 command after no-data commands", d, 32'h81);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", (n_chk + c_chk) - (n_fail + c_fail), n_chk + c_chk);
    $finish;
  end
endmodule